// File: doc/BRIEF.md
# Clock Source Disable Controller

This block sits in a system controller and decides when each of several clock sources (oscillators, PLLs) may actually be shut down. Software requests a disable through one request register. The register has three access views: a direct view that loads all request bits at once, a set view where written ones set request bits, and a clear view where written ones clear them. All three views read back the same request state. A status view reports which sources are currently valid (running and locked).

A request only takes effect when no clock domain still uses the source. Each domain supplies a source-select code, and any source named by at least one code stays valid whatever its request bit says. When the last user moves away, the source stops, its valid bit drops, and after a programmable delay a per-source low-power request goes out. Clearing the request at any time cancels that sequence. The low-power request falls in the same cycle as the request bit, and valid returns after a fixed lock time.

Top module: `clksrc_ctrl`

## Requirements
- R1: The request register at address 0 holds one bit per source in bits [NUM_SRC-1:0]. 1 means disable requested and 0 means enabled. Bits above NUM_SRC read as 0.
- R2: A write to address 0 loads the request bits from the low NUM_SRC bits of the write data.
- R3: A write to address 1 sets each request bit whose data bit is 1. A write to address 2 clears each request bit whose data bit is 1. Data bits of 0 leave the request bits unchanged.
- R4: Reads of address 1 and address 2 return the request register contents with the same 1 = disabled encoding.
- R5: Address 3 returns one valid bit per source. A bit is 1 while the source runs. The address is read-only, so writes to it change nothing.
- R6: While any domain select code equals a source index, that source stays valid and its low-power request stays 0, even with its request bit set. Codes of NUM_SRC or more select no source.
- R7: Once a source has its request bit set and no domain selects it, its valid bit goes to 0 on the next clock edge.
- R8: The low-power request of a stopped source rises D clock edges after its valid bit fell. D is the delay register value, and a value of 0 acts as 1.
- R9: The delay register at address 4 (bits [DLY_W-1:0]) is read/write and resets to 16.
- R10: Clearing a request bit drops that source's low-power request in the same cycle the bit clears. A delay still pending is cancelled and does not raise the request later.
- R11: After a request bit clears on a stopped source, valid returns 9 edges after the clearing write: one edge to enter locking, then the 8-cycle lock time.
- R12: After reset all request bits are 0, all sources are valid, and no low-power request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| dom_sel | input | NUM_DOM*SEL_W (20) | Source-select code of each domain, domain d at bits [d*SEL_W +: SEL_W] |
| src_valid | output | NUM_SRC (8) | Per-source valid status |
| src_lowpwr | output | NUM_SRC (8) | Per-source low-power request |

## Verification
The bench holds a source in use while its disable bit is set. A design that ignored domain usage would drop valid there and stop a clock that is still feeding logic. It checks the edge on which valid falls after the last user leaves, and the exact edge on which low-power rises for a short delay and for a zero delay. An off-by-one counter, or a zero delay that wraps to a 256-cycle wait, shows up there. It clears a request while the delay is still running and watches low-power for many cycles, so a design that only deasserts but never cancels the count is caught. It also counts lock cycles, writes zeros through both aliases, and writes to the read-only status address, which exposes aliases that read back something other than the shared register.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_REQ   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_SET   = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CLR   = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_VALID = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_DELAY = 3'd4;

    typedef enum logic [1:0] {
        SRC_RUN     = 2'd0,
        SRC_DRAIN   = 2'd1,
        SRC_PARKED  = 2'd2,
        SRC_LOCKING = 2'd3
    } src_state_e;

endpackage

// File: rtl/clksrc_regs.sv
module clksrc_regs
    import clksrc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int DLY_W   = 8,
    parameter int DLY_RST = 16,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic [NUM_SRC-1:0] valid_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [NUM_SRC-1:0] req_o,
    output logic [DLY_W-1:0]   delay_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] req;
        logic [DLY_W-1:0]   delay;
    } regs_t;

    regs_t r_d, r_q;
    logic [NUM_SRC-1:0] wbits;

    assign wbits = wdata_i[NUM_SRC-1:0];

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            case (addr_i)
                ADR_REQ:   r_d.req   = wbits;
                ADR_SET:   r_d.req   = r_q.req | wbits;
                ADR_CLR:   r_d.req   = r_q.req & ~wbits;
                ADR_DELAY: r_d.delay = wdata_i[DLY_W-1:0];
                default:   r_d       = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.req   <= '0;
            r_q.delay <= DLY_W'(DLY_RST);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADR_REQ, ADR_SET, ADR_CLR: rdata_o[NUM_SRC-1:0] = r_q.req;
            ADR_VALID:                 rdata_o[NUM_SRC-1:0] = valid_i;
            ADR_DELAY:                 rdata_o[DLY_W-1:0]   = r_q.delay;
            default:                   rdata_o              = '0;
        endcase
    end

    assign req_o   = r_q.req;
    assign delay_o = r_q.delay;

    // R3: ones written to the set view end up set
    p_set_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADR_SET) |=> ((req_o & $past(wbits)) == $past(wbits)));

    // R3: ones written to the clear view end up clear
    p_clr_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADR_CLR) |=> ((req_o & $past(wbits)) == '0));

    // R5: writes to the status address leave the request bits alone
    p_status_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADR_VALID) |=> $stable(req_o));

endmodule

// File: rtl/clksrc_usage.sv
module clksrc_usage #(
    parameter int NUM_SRC = 8,
    parameter int NUM_DOM = 5,
    parameter int SEL_W   = 4
) (
    input  logic [NUM_DOM*SEL_W-1:0] dom_sel_i,
    output logic [NUM_SRC-1:0]       in_use_o
);

    always_comb begin
        in_use_o = '0;
        for (int d = 0; d < NUM_DOM; d++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (dom_sel_i[d*SEL_W +: SEL_W] == SEL_W'(s)) begin
                    in_use_o[s] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/clksrc_seq.sv
module clksrc_seq
    import clksrc_pkg::*;
#(
    parameter int DLY_W    = 8,
    parameter int LOCK_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic             in_use_i,
    input  logic [DLY_W-1:0] delay_i,
    output logic             valid_o,
    output logic             lowpwr_o
);

    localparam int LOCK_W = $clog2(LOCK_CYC + 1);
    localparam int CNT_W  = (DLY_W > LOCK_W) ? DLY_W : LOCK_W;

    typedef struct packed {
        src_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;
    logic may_stop;
    logic last_tick;

    assign may_stop  = req_i && !in_use_i;
    assign last_tick = (s_q.cnt <= CNT_W'(1));

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SRC_RUN: begin
                if (may_stop) begin
                    s_d.st  = SRC_DRAIN;
                    s_d.cnt = CNT_W'(delay_i);
                end
            end
            SRC_DRAIN: begin
                if (!req_i) begin
                    s_d.st  = SRC_LOCKING;
                    s_d.cnt = CNT_W'(LOCK_CYC);
                end else if (last_tick) begin
                    s_d.st  = SRC_PARKED;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            SRC_PARKED: begin
                if (!req_i) begin
                    s_d.st  = SRC_LOCKING;
                    s_d.cnt = CNT_W'(LOCK_CYC);
                end
            end
            SRC_LOCKING: begin
                if (may_stop) begin
                    s_d.st  = SRC_DRAIN;
                    s_d.cnt = CNT_W'(delay_i);
                end else if (last_tick) begin
                    s_d.st  = SRC_RUN;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= SRC_RUN;
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid_o  = (s_q.st == SRC_RUN);
    assign lowpwr_o = (s_q.st == SRC_PARKED) && req_i;

    // R6: a source still selected by a domain keeps running
    p_hold_in_use_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_use_i && valid_o) |=> valid_o);

    // R7: a requested, unused source stops on the next edge
    p_stop_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !in_use_i && valid_o) |=> !valid_o);

    // R10: a cleared request never leads to low power one cycle later
    p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_i && !lowpwr_o) |=> !lowpwr_o);

    // R11: valid only comes back after the request was clear
    p_relock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(!req_i || in_use_i));

endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
    import clksrc_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int NUM_DOM  = 5,
    parameter int SEL_W    = 4,
    parameter int DLY_W    = 8,
    parameter int DLY_RST  = 16,
    parameter int LOCK_CYC = 8,
    parameter int DATA_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [NUM_DOM*SEL_W-1:0] dom_sel,
    output logic [NUM_SRC-1:0]       src_valid,
    output logic [NUM_SRC-1:0]       src_lowpwr
);

    logic [NUM_SRC-1:0] req;
    logic [NUM_SRC-1:0] in_use;
    logic [DLY_W-1:0]   delay;

    clksrc_regs #(
        .NUM_SRC (NUM_SRC),
        .DLY_W   (DLY_W),
        .DLY_RST (DLY_RST),
        .DATA_W  (DATA_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .valid_i (src_valid),
        .rdata_o (bus_rdata),
        .req_o   (req),
        .delay_o (delay)
    );

    clksrc_usage #(
        .NUM_SRC (NUM_SRC),
        .NUM_DOM (NUM_DOM),
        .SEL_W   (SEL_W)
    ) usage_i (
        .dom_sel_i (dom_sel),
        .in_use_o  (in_use)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        clksrc_seq #(
            .DLY_W    (DLY_W),
            .LOCK_CYC (LOCK_CYC)
        ) seq_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_i    (req[g]),
            .in_use_i (in_use[g]),
            .delay_i  (delay),
            .valid_o  (src_valid[g]),
            .lowpwr_o (src_lowpwr[g])
        );
    end

    // R12: low power is never requested for a valid source
    p_lp_not_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (src_lowpwr & src_valid) == '0);

endmodule

// File: tb/clksrc_ctrl_tb_top.sv
module clksrc_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [19:0] dom_sel = '0;
    logic [7:0]  src_valid;
    logic [7:0]  src_lowpwr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    clksrc_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .dom_sel    (dom_sel),
        .src_valid  (src_valid),
        .src_lowpwr (src_lowpwr)
    );

    typedef struct packed {
        logic [2:0]  addr;
        logic [31:0] data;
        logic [7:0]  expect_req;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 32'h0000_005A, 8'h5A},
        '{3'd1, 32'h0000_0001, 8'h5B},
        '{3'd1, 32'h0000_0000, 8'h5B},
        '{3'd2, 32'h0000_0018, 8'h43},
        '{3'd2, 32'h0000_0000, 8'h43},
        '{3'd1, 32'hFF00_0080, 8'hC3},
        '{3'd0, 32'h0000_0000, 8'h00},
        '{3'd1, 32'h0000_00A5, 8'hA5},
        '{3'd2, 32'h0000_00FF, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rd;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 reset state, R9 delay reset value, R1 request register clear
        chk("R12 valid after reset", {24'h0, src_valid}, 32'hFF);
        chk("R12 lowpwr after reset", {24'h0, src_lowpwr}, 32'h0);
        bus_read(3'd0, rd); chk("R1 R12 request after reset", rd, 32'h0);
        bus_read(3'd4, rd); chk("R9 delay reset", rd, 32'd16);

        // table walk: R2 direct, R3 aliases, R4 alias readback, R1 upper bits
        for (int v = 0; v < NVEC; v++) begin
            bus_write(VECS[v].addr, VECS[v].data);
            bus_read(3'd0, rd); chk("R1 R2 R3 request view", rd, {24'h0, VECS[v].expect_req});
            bus_read(3'd1, rd); chk("R4 set view readback", rd, {24'h0, VECS[v].expect_req});
            bus_read(3'd2, rd); chk("R4 clear view readback", rd, {24'h0, VECS[v].expect_req});
        end
        tick(12);
        chk("R11 all relocked after table", {24'h0, src_valid}, 32'hFF);

        // R5 status view read-only
        bus_write(3'd3, 32'h0000_0000);
        bus_read(3'd3, rd); chk("R5 status view unaffected", rd, 32'hFF);
        bus_read(3'd0, rd); chk("R5 request unaffected by status write", rd, 32'h0);

        // R9 delay register write
        bus_write(3'd4, 32'd5);
        bus_read(3'd4, rd); chk("R9 delay readback", rd, 32'd5);

        // R6 hold-off: domain 2 selects source 1, domain 4 uses out-of-range code
        dom_sel[11:8]  = 4'd1;
        dom_sel[19:16] = 4'd9;
        bus_write(3'd1, 32'h0000_0002);
        tick(30);
        chk("R6 source 1 held valid", {31'h0, src_valid[1]}, 32'h1);
        chk("R6 source 1 no lowpwr", {31'h0, src_lowpwr[1]}, 32'h0);

        // R7 release: valid falls on the first edge after the last user leaves
        @(negedge clk);
        dom_sel[11:8] = 4'd0;
        tick(1);
        chk("R7 valid drop", {31'h0, src_valid[1]}, 32'h0);
        // R8: low power five edges after the drop
        tick(4);
        chk("R8 lowpwr not yet", {31'h0, src_lowpwr[1]}, 32'h0);
        tick(1);
        chk("R8 lowpwr at delay", {31'h0, src_lowpwr[1]}, 32'h1);
        tick(10);
        chk("R8 lowpwr held", {31'h0, src_lowpwr[1]}, 32'h1);

        // R10 / R11: clear through the clear view
        bus_write(3'd2, 32'h0000_0002);
        chk("R10 lowpwr drops with request", {31'h0, src_lowpwr[1]}, 32'h0);
        tick(8);
        chk("R11 still locking", {31'h0, src_valid[1]}, 32'h0);
        tick(1);
        chk("R11 valid after lock", {31'h0, src_valid[1]}, 32'h1);

        // R8 zero delay acts as one
        bus_write(3'd4, 32'd0);
        bus_write(3'd1, 32'h0000_0008);
        tick(1);
        chk("R7 source 3 stopped", {31'h0, src_valid[3]}, 32'h0);
        chk("R8 zero delay not same edge", {31'h0, src_lowpwr[3]}, 32'h0);
        tick(1);
        chk("R8 zero delay lowpwr", {31'h0, src_lowpwr[3]}, 32'h1);
        bus_write(3'd2, 32'h0000_0008);
        tick(12);
        chk("R11 source 3 back", {31'h0, src_valid[3]}, 32'h1);

        // R10 cancel a pending delay
        bus_write(3'd4, 32'd20);
        bus_write(3'd1, 32'h0000_0010);
        tick(5);
        bus_write(3'd2, 32'h0000_0010);
        begin
            int lp_seen;
            lp_seen = 0;
            for (int i = 0; i < 25; i++) begin
                tick(1);
                if (src_lowpwr[4]) lp_seen++;
            end
            chk("R10 cancelled delay never asserts", lp_seen, 0);
        end
        chk("R11 source 4 back", {31'h0, src_valid[4]}, 32'h1);
        chk("R12 no stray lowpwr", {24'h0, src_lowpwr}, 32'h0);

        finish_run();
    end

endmodule